// File: doc/BRIEF.md
# Flash Block-Lock Protection Gate

This block decides, for every content-altering request aimed at a two-bank flash array, whether the request may go ahead. It also keeps the per-block software lock bits. Three tiers of protection apply in order. The first is a supply and reset tier: the reset pin and the supply-valid flag. The second is a program-voltage tier: the program-voltage-valid flag. The third is a lock tier, made of the per-block lock bits and the hardware write-protect pin. Array operations and lock-bit configuration follow different rules in the lock tier.

A requester asserts a one-cycle strobe along with a bank, a block and an operation code. Exactly one clock later the block returns a registered grant and a reason code. A granted set-lock or clear-locks command updates the lock bits on that same clock edge. The full lock vector is always visible at the outputs. Voltage sensing is done elsewhere and arrives as flags.

Top module: `lock_gate`

## Requirements
- R1: After reset all lock bits read 0 and `rsp_valid`, `rsp_grant` and `rsp_reason` are 0.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `rsp_grant` and `rsp_reason` are 0 whenever `rsp_valid` is low.
- R3: If `pin_reset_n` is low or `supply_ok` is low, a legal operation is refused with reason 1, whatever the other inputs are.
- R4: If power is good but `pgm_volt_ok` is low, a legal operation is refused with reason 2, even on a locked block with `protect_n` low.
- R5: Operation codes 0 (block erase) and 2 (word/byte write) are refused with reason 3 when the addressed block's lock bit is set and `protect_n` is low. Otherwise, with all flags good, they are granted with reason 0.
- R6: With `protect_n` high, erase and write on locked blocks are granted, and so is a bank erase on a bank holding locked blocks.
- R7: Operation code 1 (bank erase) is refused with reason 3 when any lock bit of the addressed bank is set and `protect_n` is low. Lock bits in the other bank have no effect on it.
- R8: Lock bit index is bank*BLOCKS_PER_BANK + block. A granted set-lock (code 3) sets only that bit. A granted clear-locks (code 4) clears every bit of the addressed bank and leaves the other bank untouched.
- R9: Set-lock and clear-locks are refused with reason 3 whenever `protect_n` is low and power and program voltage are good, whether or not any bit is set.
- R10: Lock bits change only in a cycle where a granted response is presented. Refused requests leave them unchanged.
- R11: Operation codes 5 to 7 are refused with reason 4. This check has priority over every other one.
- R12: A request sees the lock state produced by the request of the cycle before. A write strobed on the cycle right after a granted set-lock of the same block, with `protect_n` low, is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| req_valid | input | 1 | One-cycle request strobe |
| req_bank | input | BANK_W (1) | Bank addressed |
| req_block | input | BLK_W (5) | Block within the bank |
| req_op | input | 3 | Operation code: 0 block erase, 1 bank erase, 2 write, 3 set lock, 4 clear locks |
| protect_n | input | 1 | Hardware write-protect pin, low = protect |
| pin_reset_n | input | 1 | Device reset pin, low inhibits all writes |
| pgm_volt_ok | input | 1 | Program voltage valid flag |
| supply_ok | input | 1 | Supply voltage valid flag |
| rsp_valid | output | 1 | Decision valid, one cycle after the strobe |
| rsp_grant | output | 1 | Request may proceed |
| rsp_reason | output | 3 | 0 ok, 1 power/reset, 2 program voltage, 3 locked, 4 illegal op |
| lock_bits | output | NUM_BANKS*BLOCKS_PER_BANK (64) | Current lock bits, bank 0 in the low half |

## Verification
The checker watches the fixed one-cycle response timing on every cycle. It also watches the power, program-voltage and illegal-opcode reason codes, the refusal of lock configuration while protected, and the rule that lock bits move only alongside a grant. Whether a grant is correct for the actual lock state depends on the history of set-lock and clear-locks commands. That covers single-bit locking, whole-bank locking for bank erase, bank isolation on clear, and back-to-back ordering. So the bench's scoreboard, running its own model of the lock bits, is what shows these.

// File: rtl/lock_gate_pkg.sv
package lock_gate_pkg;

   typedef enum logic [2:0] {
      OP_BLK_ERASE  = 3'd0,
      OP_BANK_ERASE = 3'd1,
      OP_WRITE      = 3'd2,
      OP_SET_LOCK   = 3'd3,
      OP_CLR_LOCKS  = 3'd4
   } op_e;

   typedef enum logic [2:0] {
      RSN_OK     = 3'd0,
      RSN_POWER  = 3'd1,
      RSN_VPP    = 3'd2,
      RSN_LOCKED = 3'd3,
      RSN_BADOP  = 3'd4
   } reason_e;

   function automatic logic op_legal(input logic [2:0] op);
      return op <= OP_CLR_LOCKS;
   endfunction

   function automatic logic op_is_cfg(input logic [2:0] op);
      return (op == OP_SET_LOCK) || (op == OP_CLR_LOCKS);
   endfunction

endpackage

// File: rtl/lock_gate_store.sv
module lock_gate_store #(
   parameter int NUM_BANKS       = 2,
   parameter int BLOCKS_PER_BANK = 32,
   localparam int BANK_W = $clog2(NUM_BANKS),
   localparam int BLK_W  = $clog2(BLOCKS_PER_BANK),
   localparam int TOTAL  = NUM_BANKS * BLOCKS_PER_BANK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [BANK_W-1:0] bank,
   input  logic [BLK_W-1:0]  block,
   output logic [TOTAL-1:0]  bits,
   output logic              blk_locked,
   output logic              bank_locked
);

   logic [NUM_BANKS-1:0]      bank_any;
   logic [BANK_W+BLK_W-1:0]   flat_idx;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [BLOCKS_PER_BANK-1:0] row_q;
      logic                       hit;

      assign hit = (bank == BANK_W'(b));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            row_q <= '0;
         end else if (hit && clr_en) begin
            row_q <= '0;
         end else if (hit && set_en) begin
            row_q[block] <= 1'b1;
         end
      end

      assign bits[b*BLOCKS_PER_BANK +: BLOCKS_PER_BANK] = row_q;
      assign bank_any[b] = |row_q;
   end

   assign flat_idx    = {bank, block};
   assign blk_locked  = bits[flat_idx];
   assign bank_locked = bank_any[bank];

endmodule

// File: rtl/lock_gate_judge.sv
module lock_gate_judge
   import lock_gate_pkg::*;
(
   input  logic       [2:0] op,
   input  logic             protect_n,
   input  logic             pin_reset_n,
   input  logic             pgm_volt_ok,
   input  logic             supply_ok,
   input  logic             blk_locked,
   input  logic             bank_locked,
   output logic             grant,
   output reason_e          reason,
   output logic             set_en,
   output logic             clr_en
);

   logic power_bad;
   assign power_bad = !pin_reset_n || !supply_ok;

   always_comb begin
      reason = RSN_OK;
      if (!op_legal(op)) begin
         reason = RSN_BADOP;
      end else if (power_bad) begin
         reason = RSN_POWER;
      end else if (!pgm_volt_ok) begin
         reason = RSN_VPP;
      end else begin
         case (op)
            OP_BLK_ERASE,
            OP_WRITE:      if (blk_locked && !protect_n)  reason = RSN_LOCKED;
            OP_BANK_ERASE: if (bank_locked && !protect_n) reason = RSN_LOCKED;
            default:       if (!protect_n)                reason = RSN_LOCKED;
         endcase
      end
   end

   assign grant  = (reason == RSN_OK);
   assign set_en = grant && (op == OP_SET_LOCK);
   assign clr_en = grant && (op == OP_CLR_LOCKS);

endmodule

// File: rtl/lock_gate.sv
module lock_gate
   import lock_gate_pkg::*;
#(
   parameter int NUM_BANKS       = 2,
   parameter int BLOCKS_PER_BANK = 32,
   localparam int BANK_W = $clog2(NUM_BANKS),
   localparam int BLK_W  = $clog2(BLOCKS_PER_BANK),
   localparam int TOTAL  = NUM_BANKS * BLOCKS_PER_BANK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [BLK_W-1:0]  req_block,
   input  logic [2:0]        req_op,
   input  logic              protect_n,
   input  logic              pin_reset_n,
   input  logic              pgm_volt_ok,
   input  logic              supply_ok,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic [2:0]        rsp_reason,
   output logic [TOTAL-1:0]  lock_bits
);

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("lock_gate: NUM_BANKS must be a power of two, at least 2");
   end
   if (BLOCKS_PER_BANK < 2 || (BLOCKS_PER_BANK & (BLOCKS_PER_BANK - 1)) != 0) begin : g_bad_blocks
      $error("lock_gate: BLOCKS_PER_BANK must be a power of two, at least 2");
   end

   logic    blk_locked;
   logic    bank_locked;
   logic    dec_grant;
   reason_e dec_reason;
   logic    dec_set;
   logic    dec_clr;

   lock_gate_store #(
      .NUM_BANKS       (NUM_BANKS),
      .BLOCKS_PER_BANK (BLOCKS_PER_BANK)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_en      (req_valid && dec_set),
      .clr_en      (req_valid && dec_clr),
      .bank        (req_bank),
      .block       (req_block),
      .bits        (lock_bits),
      .blk_locked  (blk_locked),
      .bank_locked (bank_locked)
   );

   lock_gate_judge u_judge (
      .op          (req_op),
      .protect_n   (protect_n),
      .pin_reset_n (pin_reset_n),
      .pgm_volt_ok (pgm_volt_ok),
      .supply_ok   (supply_ok),
      .blk_locked  (blk_locked),
      .bank_locked (bank_locked),
      .grant       (dec_grant),
      .reason      (dec_reason),
      .set_en      (dec_set),
      .clr_en      (dec_clr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_grant  <= 1'b0;
         rsp_reason <= RSN_OK;
      end else begin
         rsp_valid  <= req_valid;
         rsp_grant  <= req_valid && dec_grant;
         rsp_reason <= req_valid ? dec_reason : RSN_OK;
      end
   end

endmodule

// File: rtl/lock_gate_chk.sv
module lock_gate_chk #(
   parameter int TOTAL = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [2:0]       req_op,
   input logic             protect_n,
   input logic             pin_reset_n,
   input logic             pgm_volt_ok,
   input logic             supply_ok,
   input logic             rsp_valid,
   input logic             rsp_grant,
   input logic [2:0]       rsp_reason,
   input logic [TOTAL-1:0] lock_bits
);

   logic legal, power_ok, cfg;
   assign legal    = req_op <= 3'd4;
   assign power_ok = pin_reset_n && supply_ok;
   assign cfg      = (req_op == 3'd3) || (req_op == 3'd4);

   assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_quiet_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_grant && rsp_reason == 3'd0));

   assert_power_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && legal && !power_ok) |=> (!rsp_grant && rsp_reason == 3'd1));

   assert_vpp_refuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && legal && power_ok && !pgm_volt_ok) |=> (!rsp_grant && rsp_reason == 3'd2));

   assert_cfg_protected_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cfg && power_ok && pgm_volt_ok && !protect_n) |=> rsp_reason == 3'd3);

   assert_bits_need_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lock_bits) |-> (rsp_valid && rsp_grant));

   assert_bad_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !legal) |=> (!rsp_grant && rsp_reason == 3'd4));

endmodule

bind lock_gate lock_gate_chk #(.TOTAL(NUM_BANKS * BLOCKS_PER_BANK)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_op      (req_op),
   .protect_n   (protect_n),
   .pin_reset_n (pin_reset_n),
   .pgm_volt_ok (pgm_volt_ok),
   .supply_ok   (supply_ok),
   .rsp_valid   (rsp_valid),
   .rsp_grant   (rsp_grant),
   .rsp_reason  (rsp_reason),
   .lock_bits   (lock_bits)
);

// File: tb/lock_gate_tb.sv
`timescale 1ns/1ps
module lock_gate_tb;

   localparam int NB  = 2;
   localparam int BPB = 32;
   localparam int TOT = NB * BPB;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           req_valid;
   logic [0:0]     req_bank;
   logic [4:0]     req_block;
   logic [2:0]     req_op;
   logic           protect_n, pin_reset_n, pgm_volt_ok, supply_ok;
   logic           rsp_valid, rsp_grant;
   logic [2:0]     rsp_reason;
   logic [TOT-1:0] lock_bits;

   always #2.5 clk = ~clk;

   lock_gate #(.NUM_BANKS(NB), .BLOCKS_PER_BANK(BPB)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
      .req_block(req_block), .req_op(req_op), .protect_n(protect_n),
      .pin_reset_n(pin_reset_n), .pgm_volt_ok(pgm_volt_ok), .supply_ok(supply_ok),
      .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_reason(rsp_reason),
      .lock_bits(lock_bits)
   );

   int             total = 0;
   int             bad   = 0;
   bit             done  = 0;
   logic [TOT-1:0] model = '0;
   logic [TOT+3:0] exp_q[$];
   string          tag_q[$];

   task automatic check(input bit ok, input string tag, input string act, input string exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual %s expected %s", tag, act, exp);
      end
   endtask

   task automatic send(input int bank, input int blk, input int op, input bit wp,
                       input bit rp, input bit vpp, input bit vcc, input string tag);
      logic [2:0] r;
      int         idx;
      bit         anyl;
      idx  = bank * BPB + blk;
      anyl = |model[bank*BPB +: BPB];
      if (op > 4)            r = 3'd4;
      else if (!rp || !vcc)  r = 3'd1;
      else if (!vpp)         r = 3'd2;
      else begin
         case (op)
            0, 2:    r = (model[idx] && !wp) ? 3'd3 : 3'd0;
            1:       r = (anyl && !wp) ? 3'd3 : 3'd0;
            default: r = wp ? 3'd0 : 3'd3;
         endcase
      end
      if (r == 3'd0 && op == 3) model[idx] = 1'b1;
      if (r == 3'd0 && op == 4) model[bank*BPB +: BPB] = '0;
      exp_q.push_back({r == 3'd0, r, model});
      tag_q.push_back(tag);
      @(negedge clk);
      req_valid   = 1'b1;
      req_bank    = bank[0:0];
      req_block   = blk[4:0];
      req_op      = op[2:0];
      protect_n   = wp;
      pin_reset_n = rp;
      pgm_volt_ok = vpp;
      supply_ok   = vcc;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (rsp_valid) begin
            if (exp_q.size() == 0) begin
               check(0, "R2 unexpected response", "rsp_valid=1", "rsp_valid=0");
            end else begin
               logic [TOT+3:0] e;
               string          t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check({rsp_grant, rsp_reason, lock_bits} == e, t,
                     $sformatf("grant=%0d reason=%0d bits=%h", rsp_grant, rsp_reason, lock_bits),
                     $sformatf("grant=%0d reason=%0d bits=%h", e[TOT+3], e[TOT+2:TOT], e[TOT-1:0]));
            end
         end else begin
            check(!rsp_grant && rsp_reason == 3'd0, "R2 quiet outputs",
                  $sformatf("grant=%0d reason=%0d", rsp_grant, rsp_reason), "grant=0 reason=0");
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++;
         total++;
         $display("FAIL R2 watchdog: actual hung expected finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_bank = '0; req_block = '0; req_op = '0;
      protect_n = 1'b0; pin_reset_n = 1'b1; pgm_volt_ok = 1'b1; supply_ok = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(lock_bits == '0, "R1 lock bits after reset", $sformatf("%h", lock_bits), "0");
      check(!rsp_valid && !rsp_grant && rsp_reason == 3'd0, "R1 response after reset",
            $sformatf("v=%0d g=%0d r=%0d", rsp_valid, rsp_grant, rsp_reason), "v=0 g=0 r=0");

      send(0, 5, 2, 0, 1, 1, 1, "R5 write unlocked block");
      send(0, 5, 3, 1, 1, 1, 1, "R8 set lock bank0 blk5");
      send(0, 5, 2, 0, 1, 1, 1, "R5 write locked protected");
      send(0, 5, 0, 0, 1, 1, 1, "R5 erase locked protected");
      send(0, 6, 0, 0, 1, 1, 1, "R5 erase neighbour unlocked");
      idle(2);
      send(0, 5, 2, 1, 1, 1, 1, "R6 write locked unprotected");
      send(0, 5, 0, 1, 1, 1, 1, "R6 erase locked unprotected");
      send(0, 0, 1, 0, 1, 1, 1, "R7 bank erase with locked block");
      send(1, 0, 1, 0, 1, 1, 1, "R7 bank erase other bank");
      send(0, 0, 1, 1, 1, 1, 1, "R6 bank erase unprotected");
      send(1, 9, 3, 0, 1, 1, 1, "R9 set lock while protected");
      send(0, 5, 4, 0, 1, 1, 1, "R9 clear locks while protected");
      idle(1);
      send(0, 6, 2, 1, 0, 1, 1, "R3 reset pin low");
      send(0, 6, 3, 1, 1, 0, 0, "R3 supply low beats vpp");
      send(0, 5, 2, 0, 1, 0, 1, "R4 vpp low beats lock");
      send(0, 6, 3, 1, 1, 0, 1, "R4 vpp low on set lock");
      send(0, 6, 5, 1, 0, 1, 0, "R11 bad op beats power");
      send(1, 3, 7, 1, 1, 1, 1, "R11 bad op 7");
      send(1, 31, 3, 1, 1, 1, 1, "R8 set lock top bit");
      send(1, 0, 3, 1, 1, 1, 1, "R8 set lock bank1 blk0");
      send(0, 2, 4, 1, 1, 1, 1, "R8 clear bank0 keeps bank1");
      send(0, 5, 2, 0, 1, 1, 1, "R8 cleared block writable");
      send(1, 31, 2, 0, 1, 1, 1, "R10 bank1 still locked");
      idle(3);
      send(0, 7, 3, 1, 1, 1, 1, "R12 set lock then");
      send(0, 7, 2, 0, 1, 1, 1, "R12 back-to-back write refused");
      send(0, 7, 4, 1, 1, 1, 1, "R12 clear then");
      send(0, 7, 0, 0, 1, 1, 1, "R12 back-to-back erase granted");
      idle(4);
      check(exp_q.size() == 0, "R2 all responses seen",
            $sformatf("%0d pending", exp_q.size()), "0 pending");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule